// File: doc/BRIEF.md
# Limited-Tone Frequency Classifier

This block takes a one-bit, hard-limited tone signal that is already synchronous to the system clock (nominally 560 kHz). It decides which tone of a fixed set is present and reports the tone's 4-bit index. It measures the input period by counting clock cycles from one rising edge to the next. It then compares that period against a parameter table of minimum and maximum period counts, one pair per tone. A period counts as a hit only when it falls inside exactly one window.

A tone is accepted only after several consecutive hits on the same table entry, which gives a qualification time of about 25 ms at the defaults. When accepted, the tone drives the code output and raises a one-cycle new-tone strobe. The code returns to the reserved no-tone value 0xF only after a longer release interval with no hits. A tone that repeats with the same index is accepted again as a new event only when a minimum gap with no hits came before it. The window table is set at elaboration, so either common tone set can be built from the same RTL.

Top module: `tone_classifier`

## Requirements
- R1: During and right after reset, `code` is 0xF, `tone_present` is 0 and `new_tone` is 0.
- R2: Table entry i is reported on `code` as the value i (0 to TONES-1), and 0xF is reserved for "no tone". `tone_present` is 1 exactly when `code` is not 0xF.
- R3: A period is the number of clock cycles between consecutive rising edges of `tone_in`. A period matches entry i when MIN_TAB[i] <= period <= MAX_TAB[i] holds for that entry and for no other entry. Entry i occupies bits [i*CNT_W +: CNT_W] of each table. A period that falls in no window, or in two or more windows, is not a match.
- R4: A tone is qualified by QUAL_RUNS consecutive matching periods for the same entry. Any non-matching period, or a period that matches another entry, restarts the count. Starting from silence with period P, the code appears no earlier than QUAL_RUNS*P cycles after the tone's first driven cycle and no more than 4 cycles later than that.
- R5: `new_tone` is a one-cycle pulse, raised in the same cycle as `code` takes a newly accepted tone. This includes a direct change from one valid tone to another without passing through 0xF.
- R6: After RELEASE_CYC cycles with no matching period, `code` returns to 0xF without a `new_tone` pulse. The change appears between RELEASE_CYC and RELEASE_CYC+4 cycles after the last rising edge that ended a matching period.
- R7: A qualified tone with the same index as the current code raises `new_tone` again only if at least GAP_CYC cycles without a matching period came before it. A shorter break leaves `code` unchanged and gives no strobe.
- R8: The period counter saturates at 2**CNT_W-1 and does not wrap. A period of that length or longer never matches, and the first rising edge after reset never matches.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock (nominally 560 kHz) |
| rst | input | 1 | Synchronous reset, active high |
| tone_in | input | 1 | Limited tone signal, already synchronous to `clk` |
| code | output | 4 | Index of the qualified tone, 0xF for no tone |
| new_tone | output | 1 | One-cycle pulse when a tone is accepted |
| tone_present | output | 1 | High while `code` holds a valid tone |

## Verification
The hardest behaviour to reach from the ports is the difference between a repeat of the same tone after a short break and a repeat after a real gap. Both must produce a fresh qualification run, but only one may strobe, and neither may let the release timer expire. The stimulus holds one tone until it is accepted, pauses for a silence shorter than GAP_CYC, then replays the tone and expects no strobe. It then pauses for a silence longer than GAP_CYC but still short of RELEASE_CYC, replays the tone, and expects a strobe with the same code. A separate long single pulse is sized so that a counter that wrapped instead of saturating would read an in-window period, which exposes the R8 fault as a strobe one period early.

// File: rtl/tone_pkg.sv
package tone_pkg;

  typedef logic [3:0] code_t;

  localparam code_t NO_TONE = 4'hF;

  // Increment that holds at the limit instead of wrapping.
  function automatic int unsigned sat_inc(int unsigned v, int unsigned lim);
    return (v >= lim) ? lim : v + 1;
  endfunction

  // Inclusive window test on a period count.
  function automatic logic in_window(int unsigned p, int unsigned lo, int unsigned hi);
    return (p >= lo) && (p <= hi);
  endfunction

endpackage

// File: rtl/tone_period_meter.sv
module tone_period_meter #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tone_in,
  output logic             per_valid,
  output logic [CNT_W-1:0] per_val,
  output logic             per_sat
);
  import tone_pkg::*;

  localparam int unsigned CNT_MAX = (1 << CNT_W) - 1;

  logic             prev_q;
  logic [CNT_W-1:0] cnt_q;
  logic             rise;

  assign rise    = tone_in & ~prev_q;
  assign per_sat = (per_val == CNT_W'(CNT_MAX));

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q    <= 1'b0;
      cnt_q     <= CNT_W'(CNT_MAX);
      per_valid <= 1'b0;
      per_val   <= '0;
    end else begin
      prev_q    <= tone_in;
      per_valid <= rise;
      if (rise) begin
        per_val <= CNT_W'(sat_inc(32'(cnt_q), CNT_MAX));
        cnt_q   <= '0;
      end else begin
        cnt_q   <= CNT_W'(sat_inc(32'(cnt_q), CNT_MAX));
      end
    end
  end

endmodule

// File: rtl/tone_window_match.sv
module tone_window_match #(
  parameter int                      TONES   = 6,
  parameter int                      CNT_W   = 12,
  parameter logic [TONES*CNT_W-1:0]  MIN_TAB = '0,
  parameter logic [TONES*CNT_W-1:0]  MAX_TAB = '0
) (
  input  logic             [CNT_W-1:0] per_val,
  input  logic                         per_sat,
  output logic                         hit,
  output tone_pkg::code_t              idx
);
  import tone_pkg::*;

  logic [TONES-1:0] in_win;

  for (genvar g = 0; g < TONES; g++) begin : g_win
    assign in_win[g] = !per_sat &&
                       in_window(32'(per_val),
                                 32'(MIN_TAB[g*CNT_W +: CNT_W]),
                                 32'(MAX_TAB[g*CNT_W +: CNT_W]));
  end

  assign hit = ($countones(in_win) == 1);

  always_comb begin
    idx = '0;
    for (int i = 0; i < TONES; i++) begin
      if (in_win[i]) idx = code_t'(i);
    end
  end

endmodule

// File: rtl/tone_qualifier.sv
module tone_qualifier #(
  parameter int QUAL_RUNS   = 25,
  parameter int GAP_CYC     = 11200,
  parameter int RELEASE_CYC = 22400,
  parameter int IDLE_W      = $clog2(RELEASE_CYC + 1)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  per_valid,
  input  logic                  hit,
  input  tone_pkg::code_t       idx,
  output tone_pkg::code_t       code,
  output logic                  new_tone,
  output logic [IDLE_W-1:0]     idle_cnt
);
  import tone_pkg::*;

  localparam int RUN_W = $clog2(QUAL_RUNS + 1);

  code_t             code_q;
  code_t             run_idx_q;
  logic [RUN_W-1:0]  run_q;
  logic [RUN_W-1:0]  run_nxt;
  logic [IDLE_W-1:0] idle_q;
  logic              gap_q;
  logic              strobe_q;

  logic match_evt, miss_evt, same_run, qual_evt, accept_evt, release_evt;

  assign match_evt  = per_valid & hit;
  assign miss_evt   = per_valid & ~hit;
  assign same_run   = (run_q != '0) && (run_idx_q == idx);
  assign run_nxt    = same_run ? RUN_W'(sat_inc(32'(run_q), QUAL_RUNS)) : RUN_W'(1);
  assign qual_evt   = match_evt && (run_nxt == RUN_W'(QUAL_RUNS)) &&
                      !(same_run && run_q == RUN_W'(QUAL_RUNS));
  assign accept_evt = qual_evt && ((idx != code_q) || gap_q);
  assign release_evt = !match_evt && (code_q != NO_TONE) &&
                       (idle_q == IDLE_W'(RELEASE_CYC - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      code_q    <= NO_TONE;
      run_idx_q <= '0;
      run_q     <= '0;
      idle_q    <= IDLE_W'(RELEASE_CYC);
      gap_q     <= 1'b1;
      strobe_q  <= 1'b0;
    end else begin
      strobe_q <= accept_evt;

      if (match_evt) begin
        run_q     <= run_nxt;
        run_idx_q <= idx;
        idle_q    <= '0;
      end else begin
        if (miss_evt) run_q <= '0;
        idle_q <= (idle_q == IDLE_W'(RELEASE_CYC)) ? idle_q : idle_q + 1'b1;
      end

      if (accept_evt)                         gap_q <= 1'b0;
      else if (idle_q >= IDLE_W'(GAP_CYC))    gap_q <= 1'b1;

      if (accept_evt)       code_q <= idx;
      else if (release_evt) code_q <= NO_TONE;
    end
  end

  assign code     = code_q;
  assign new_tone = strobe_q;
  assign idle_cnt = idle_q;

endmodule

// File: rtl/tone_classifier.sv
module tone_classifier #(
  parameter int                     TONES       = 6,
  parameter int                     CNT_W       = 12,
  parameter logic [TONES*CNT_W-1:0] MIN_TAB     = {12'd316, 12'd344, 12'd378, 12'd418, 12'd469, 12'd534},
  parameter logic [TONES*CNT_W-1:0] MAX_TAB     = {12'd332, 12'd362, 12'd397, 12'd440, 12'd493, 12'd561},
  parameter int                     QUAL_RUNS   = 25,
  parameter int                     GAP_CYC     = 11200,
  parameter int                     RELEASE_CYC = 22400
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tone_in,
  output logic [3:0] code,
  output logic       new_tone,
  output logic       tone_present
);
  import tone_pkg::*;

  localparam int IDLE_W = $clog2(RELEASE_CYC + 1);

  initial begin
    if (TONES < 1 || TONES > 15) $error("TONES must lie in 1..15");
    if (QUAL_RUNS < 2)           $error("QUAL_RUNS must be at least 2");
    if (GAP_CYC >= RELEASE_CYC)  $error("GAP_CYC must be below RELEASE_CYC");
  end

  logic              per_valid;
  logic [CNT_W-1:0]  per_val;
  logic              per_sat;
  logic              match_hit;
  code_t             match_idx;
  code_t             code_int;
  logic [IDLE_W-1:0] idle_cnt;

  tone_period_meter #(.CNT_W(CNT_W)) u_meter (
    .clk      (clk),
    .rst      (rst),
    .tone_in  (tone_in),
    .per_valid(per_valid),
    .per_val  (per_val),
    .per_sat  (per_sat)
  );

  tone_window_match #(
    .TONES  (TONES),
    .CNT_W  (CNT_W),
    .MIN_TAB(MIN_TAB),
    .MAX_TAB(MAX_TAB)
  ) u_match (
    .per_val(per_val),
    .per_sat(per_sat),
    .hit    (match_hit),
    .idx    (match_idx)
  );

  tone_qualifier #(
    .QUAL_RUNS  (QUAL_RUNS),
    .GAP_CYC    (GAP_CYC),
    .RELEASE_CYC(RELEASE_CYC),
    .IDLE_W     (IDLE_W)
  ) u_qual (
    .clk      (clk),
    .rst      (rst),
    .per_valid(per_valid),
    .hit      (match_hit),
    .idx      (match_idx),
    .code     (code_int),
    .new_tone (new_tone),
    .idle_cnt (idle_cnt)
  );

  assign code         = code_int;
  assign tone_present = (code_int != NO_TONE);

endmodule

// File: rtl/tone_classifier_chk.sv
module tone_classifier_chk #(
  parameter int TONES       = 6,
  parameter int IDLE_W      = 15,
  parameter int RELEASE_CYC = 22400
) (
  input logic              clk,
  input logic              rst,
  input logic [3:0]        code,
  input logic              new_tone,
  input logic              tone_present,
  input logic              per_valid,
  input logic [IDLE_W-1:0] idle_cnt
);

  // R1: the cycle after reset leaves the no-tone state with no strobe
  a_r1_reset_state: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (code == 4'hF && !new_tone && !tone_present));

  // R2: code is a table index or the reserved value
  a_r2_code_range: assert property (@(posedge clk) disable iff (rst)
    (code == 4'hF) || (32'(code) < TONES));

  // R2: presence flag tracks the code
  a_r2_present: assert property (@(posedge clk) disable iff (rst)
    tone_present == (code != 4'hF));

  // R4: a move to a valid code follows a period measurement
  a_r4_change_on_period: assert property (@(posedge clk) disable iff (rst)
    (code != $past(code) && code != 4'hF) |-> $past(per_valid));

  // R5: strobe names a valid tone and lasts a single cycle
  a_r5_strobe_valid: assert property (@(posedge clk) disable iff (rst)
    new_tone |-> code != 4'hF);
  a_r5_strobe_single: assert property (@(posedge clk) disable iff (rst)
    new_tone |=> !new_tone);

  // R6: release has no strobe and happens at the end of the idle interval
  a_r6_release_quiet: assert property (@(posedge clk) disable iff (rst)
    (code == 4'hF && $past(code) != 4'hF) |-> !new_tone);
  a_r6_release_timed: assert property (@(posedge clk) disable iff (rst)
    (code == 4'hF && $past(code) != 4'hF) |-> $past(idle_cnt) == IDLE_W'(RELEASE_CYC - 1));

endmodule

bind tone_classifier tone_classifier_chk #(
  .TONES      (TONES),
  .IDLE_W     (IDLE_W),
  .RELEASE_CYC(RELEASE_CYC)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .code        (code),
  .new_tone    (new_tone),
  .tone_present(tone_present),
  .per_valid   (per_valid),
  .idle_cnt    (idle_cnt)
);

// File: tb/tone_classifier_test.sv
`timescale 1ns/1ps
module tone_classifier_test;

  localparam int TONES   = 4;
  localparam int CNT_W   = 8;
  localparam int QUAL    = 4;
  localparam int GAP     = 150;
  localparam int RELEASE = 400;
  // windows: 0:[20,24] 1:[30,34] 2:[40,44] 3:[43,50] (2 and 3 overlap at 43..44)
  localparam logic [TONES*CNT_W-1:0] MINS = {8'd43, 8'd40, 8'd30, 8'd20};
  localparam logic [TONES*CNT_W-1:0] MAXS = {8'd50, 8'd44, 8'd34, 8'd24};

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tone_in = 1'b0;
  logic [3:0] code;
  logic       new_tone;
  logic       tone_present;

  tone_classifier #(
    .TONES(TONES), .CNT_W(CNT_W), .MIN_TAB(MINS), .MAX_TAB(MAXS),
    .QUAL_RUNS(QUAL), .GAP_CYC(GAP), .RELEASE_CYC(RELEASE)
  ) uut (
    .clk(clk), .rst(rst), .tone_in(tone_in),
    .code(code), .new_tone(new_tone), .tone_present(tone_present)
  );

  always #2 clk = ~clk;

  int total = 0;
  int fails = 0;
  int cyc = 0;
  int strobes = 0;
  int last_strobe = 0;
  int last_rel = 0;
  bit done = 1'b0;
  logic [3:0] prev_code = 4'hF;
  logic [3:0] exp_q[$];

  always @(posedge clk) cyc++;

  task automatic check(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Monitor: pops expected codes as strobes appear, records release times.
  always @(negedge clk) begin
    if (!rst) begin
      if (new_tone) begin
        strobes++;
        last_strobe = cyc;
        if (exp_q.size() == 0) check(1'b0, "R5 unexpected strobe", code, 15);
        else begin
          logic [3:0] e;
          e = exp_q.pop_front();
          check(code == e, "R5 strobe code", code, e);
        end
      end
      if (code != prev_code && code == 4'hF) last_rel = cyc;
      prev_code = code;
    end
  end

  task automatic play(int p, int n);
    for (int k = 0; k < n; k++)
      for (int c = 0; c < p; c++) begin
        @(negedge clk);
        tone_in = (c < p / 2);
      end
  endtask

  task automatic silence(int n);
    for (int c = 0; c < n; c++) begin
      @(negedge clk);
      tone_in = 1'b0;
    end
  endtask

  task automatic qualify(int p, int n, logic [3:0] e, string req);
    int s;
    exp_q.push_back(e);
    s = cyc;
    play(p, n);
    check(last_strobe - s >= QUAL * p && last_strobe - s <= QUAL * p + 4, req, last_strobe - s, QUAL * p);
    check(code == e, req, code, e);
  endtask

  task automatic release_check(int p, string req);
    int e;
    int n0;
    e = cyc;
    n0 = strobes;
    silence(RELEASE + 40);
    check(last_rel - (e - p) >= RELEASE && last_rel - (e - p) <= RELEASE + 4, req, last_rel - (e - p), RELEASE);
    check(code == 4'hF && !tone_present, req, code, 15);
    check(strobes == n0, req, strobes, n0);
  endtask

  initial begin
    int n0;
    repeat (5) @(negedge clk);
    check(code == 4'hF && !new_tone && !tone_present, "R1 in reset", code, 15);
    rst = 1'b0;
    @(negedge clk);
    check(code == 4'hF && !new_tone && !tone_present, "R1 after reset", code, 15);

    // R4/R8: first tone, first edge after reset unmatched
    qualify(22, 8, 4'd0, "R4 qualify entry 0");
    check(tone_present == 1'b1, "R2 present", tone_present, 1);

    // R5: direct switch to another tone
    qualify(32, 8, 4'd1, "R5 direct switch");

    // R6: release
    release_check(32, "R6 release");

    // R3: overlap region and out-of-window periods never match
    n0 = strobes;
    play(43, 10);
    check(code == 4'hF && strobes == n0, "R3 overlap ignored", code, 15);
    play(25, 8);
    check(code == 4'hF && strobes == n0, "R3 above max", code, 15);
    play(19, 8);
    check(code == 4'hF && strobes == n0, "R3 below min", code, 15);

    // R3: window edges are inclusive
    qualify(20, 6, 4'd0, "R3 min edge");
    qualify(34, 6, 4'd1, "R3 max edge");

    // R4: an interrupted run does not qualify
    n0 = strobes;
    play(22, 3);
    play(27, 1);
    play(22, 3);
    check(code == 4'd1 && strobes == n0, "R4 broken run", code, 1);
    release_check(22, "R6 second release");

    // R7: same tone after short and long breaks
    qualify(42, 6, 4'd2, "R7 first accept");
    n0 = strobes;
    silence(60);
    play(42, 6);
    check(code == 4'd2 && strobes == n0, "R7 short break no strobe", strobes, n0);
    silence(200);
    qualify(42, 6, 4'd2, "R7 gap re-accept");

    // R2: entry 3 outside the overlap
    qualify(47, 6, 4'd3, "R2 entry 3");
    release_check(47, "R6 third release");

    // R8: long period that would alias to 22 if the counter wrapped
    for (int c = 0; c < 278; c++) begin
      @(negedge clk);
      tone_in = (c < 11);
    end
    qualify(22, 6, 4'd0, "R8 saturation");

    silence(20);
    check(exp_q.size() == 0, "R5 missing strobes", exp_q.size(), 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

endmodule